// File: doc/BRIEF.md
# CMI Line Decoder with Nibble Output

This block turns a Coded Mark Inversion line stream into NRZ data. The line is sampled at twice the bit rate. One clock runs the whole block, and a sample strobe marks each cycle that carries a new line sample, so the same logic serves any line rate that fits under the clock. A select input picks one of two serial sources, for example an optical-side receiver or an equalised coaxial input. A mode input chooses between CMI decoding and plain NRZ pass-through.

In CMI mode the block groups line samples into half-bit pairs and decodes each pair into one data bit. It flags pairs that break the code, and it moves its pair boundary by one half-bit when violations cluster. Decoded bits leave on two streams:
- a retimed bit-serial output;
- a nibble output carrying four bits per word.

Both output streams are valid-only pulses with no ready input. A line cannot be stalled, so the block applies no back-pressure. The sink must take every beat in the cycle its valid is high.

Top module: `cmi_nibble_decoder`

## Requirements
- R1: With `src_sel` = 0 the decoder takes its samples from `line_a`, and with `src_sel` = 1 from `line_b`. The unselected input has no effect.
- R2: With `cmi_mode` = 1, two consecutive accepted samples (`smp_en` high) form a pair, and the first sample is the first half. Pair 01 decodes to 0, and pairs 00 and 11 decode to 1. `ser_valid` and `ser_data` appear one cycle after the clock edge that accepts the second half.
- R3: With `cmi_mode` = 0, every accepted sample is one output bit equal to the sample, with the same latency as R2. `code_viol` stays low.
- R4: A pair 10 sets `code_viol` high together with `ser_valid` and is output as data 0.
- R5: A 1 whose pair level equals that of the previous 1 sets `code_viol` and is still output as data 1. The first 1 after reset is never flagged.
- R6: Bits are packed MSB first: the first bit after reset lands in `nib_data[3]`. `nib_valid` pulses one cycle after every fourth `ser_valid`.
- R7: When 4 violations fall within a block of 16 consecutive pairs, `align_slip` pulses once and the pair boundary moves by one half-bit. The block does this by discarding a held first half, or the next sample if no first half is held.
- R8: After a slip, the next 16 pairs are not counted. The next slip therefore needs at least 16 + 4 = 20 further decoded pairs.
- R9: A synchronous active-high `rst` clears the pair phase, the last-one level, the nibble count and the violation counters. In the cycle after reset, all valid, violation and slip outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Line sample strobe (one per half-bit in CMI mode, one per bit in NRZ mode) |
| line_a | input | 1 | Serial source 0 |
| line_b | input | 1 | Serial source 1 |
| src_sel | input | 1 | Source select: 0 = line_a, 1 = line_b |
| cmi_mode | input | 1 | 1 = CMI decoding, 0 = NRZ pass-through |
| ser_data | output | 1 | Retimed decoded bit |
| ser_valid | output | 1 | ser_data valid pulse |
| nib_data | output | 4 | Packed nibble, first bit in MSB |
| nib_valid | output | 1 | nib_data valid pulse |
| code_viol | output | 1 | Code violation on the current decoded bit |
| align_slip | output | 1 | Pair boundary moved by one half-bit |

## Verification
The bound checker watches four rules on every cycle:
- no violation is reported unless CMI mode was active when the pair closed;
- every violation coincides with a decoded bit;
- a nibble only follows a decoded bit;
- slips are spaced by at least the hold window plus the threshold.

Only the directed scenarios can show the decoded values themselves: the pair codes, the alternation of ones, MSB-first packing and source selection. They also show that a half-bit slip actually restores clean decoding, and that exactly twenty pairs separate slips under a continuous violation stream.

// File: rtl/cmi_dec_pkg.sv
package cmi_dec_pkg;
  // One half-bit pair, or one NRZ bit when cmi is low (hi == lo then)
  typedef struct packed {
    logic vld;
    logic cmi;
    logic hi;
    logic lo;
  } cmi_pair_t;

  // One decoded bit with its violation flag
  typedef struct packed {
    logic vld;
    logic cmi;
    logic dat;
    logic viol;
  } cmi_bit_t;
endpackage

// File: rtl/cmi_pair_former.sv
module cmi_pair_former
  import cmi_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      smp_en,
  input  logic      smp,
  input  logic      cmi_mode,
  input  logic      slip_req,
  output cmi_pair_t pair_o
);
  logic phase;   // 1: first half held
  logic held;
  logic pend;    // slip requested with nothing held: drop the next sample

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 1'b0;
      held   <= 1'b0;
      pend   <= 1'b0;
      pair_o <= '0;
    end else begin
      pair_o.vld <= 1'b0;
      if (!cmi_mode) begin
        phase <= 1'b0;
        pend  <= 1'b0;
        if (smp_en) begin
          pair_o.vld <= 1'b1;
          pair_o.cmi <= 1'b0;
          pair_o.hi  <= smp;
          pair_o.lo  <= smp;
        end
      end else if (smp_en) begin
        pend <= 1'b0;
        if (slip_req || pend) begin
          // shift by one half: replace the held half, or discard this sample
          if (phase) held <= smp;
        end else if (!phase) begin
          held  <= smp;
          phase <= 1'b1;
        end else begin
          pair_o.vld <= 1'b1;
          pair_o.cmi <= 1'b1;
          pair_o.hi  <= held;
          pair_o.lo  <= smp;
          phase      <= 1'b0;
        end
      end else if (slip_req) begin
        if (phase) phase <= 1'b0;
        else       pend  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmi_symbol_decode.sv
module cmi_symbol_decode
  import cmi_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cmi_pair_t pair_i,
  output cmi_bit_t  bit_o
);
  logic seen_one;
  logic last_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_one <= 1'b0;
      last_lvl <= 1'b0;
      bit_o    <= '0;
    end else begin
      bit_o.vld  <= pair_i.vld;
      bit_o.cmi  <= pair_i.cmi;
      bit_o.dat  <= 1'b0;
      bit_o.viol <= 1'b0;
      if (pair_i.vld) begin
        if (!pair_i.cmi) begin
          bit_o.dat <= pair_i.hi;
        end else begin
          unique case ({pair_i.hi, pair_i.lo})
            2'b01: bit_o.dat <= 1'b0;
            2'b10: bit_o.viol <= 1'b1;
            default: begin
              bit_o.dat  <= 1'b1;
              bit_o.viol <= seen_one && (last_lvl == pair_i.hi);
              seen_one   <= 1'b1;
              last_lvl   <= pair_i.hi;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cmi_align_ctrl.sv
module cmi_align_ctrl
  import cmi_dec_pkg::*;
#(
  parameter int WIN_PAIRS  = 16,
  parameter int VIOL_THR   = 4,
  parameter int HOLD_PAIRS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  cmi_bit_t bit_i,
  output logic     slip_o
);
  localparam int WW = (WIN_PAIRS > 2) ? $clog2(WIN_PAIRS) : 1;
  localparam int VW = (VIOL_THR > 2) ? $clog2(VIOL_THR) : 1;
  localparam int HW = $clog2(HOLD_PAIRS + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_PAIRS - 1);
  localparam logic [VW-1:0] VIOL_LAST = VW'(VIOL_THR - 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_PAIRS);

  logic [WW-1:0] win_cnt;
  logic [VW-1:0] viol_cnt;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      viol_cnt <= '0;
      hold_cnt <= '0;
      slip_o   <= 1'b0;
    end else begin
      slip_o <= 1'b0;
      if (bit_i.vld && bit_i.cmi) begin
        if (hold_cnt != '0) begin
          hold_cnt <= hold_cnt - 1'b1;
        end else if (bit_i.viol && viol_cnt == VIOL_LAST) begin
          slip_o   <= 1'b1;
          hold_cnt <= HOLD_LD;
          win_cnt  <= '0;
          viol_cnt <= '0;
        end else if (win_cnt == WIN_LAST) begin
          win_cnt  <= '0;
          viol_cnt <= '0;
        end else begin
          win_cnt  <= win_cnt + 1'b1;
          viol_cnt <= viol_cnt + VW'(bit_i.viol);
        end
      end
    end
  end
endmodule

// File: rtl/cmi_nibble_packer.sv
module cmi_nibble_packer #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_dat,
  output logic [NIB_W-1:0] nib_o,
  output logic             nib_vld
);
  localparam int CW = $clog2(NIB_W);
  localparam logic [CW-1:0] LAST = CW'(NIB_W - 1);

  logic [CW-1:0]    cnt;
  logic [NIB_W-2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sh      <= '0;
      nib_o   <= '0;
      nib_vld <= 1'b0;
    end else begin
      nib_vld <= 1'b0;
      if (bit_vld) begin
        sh  <= {sh[NIB_W-3:0], bit_dat};
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          nib_o   <= {sh, bit_dat};
          nib_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmi_nibble_decoder.sv
module cmi_nibble_decoder
  import cmi_dec_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int WIN_PAIRS  = 16,
  parameter int VIOL_THR   = 4,
  parameter int HOLD_PAIRS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_en,
  input  logic             line_a,
  input  logic             line_b,
  input  logic             src_sel,
  input  logic             cmi_mode,
  output logic             ser_data,
  output logic             ser_valid,
  output logic [NIB_W-1:0] nib_data,
  output logic             nib_valid,
  output logic             code_viol,
  output logic             align_slip
);
  logic      smp;
  cmi_pair_t pair;
  cmi_bit_t  dbit;

  assign smp = src_sel ? line_b : line_a;

  cmi_pair_former u_pair (
    .clk(clk), .rst(rst), .smp_en(smp_en), .smp(smp),
    .cmi_mode(cmi_mode), .slip_req(align_slip), .pair_o(pair)
  );

  cmi_symbol_decode u_dec (
    .clk(clk), .rst(rst), .pair_i(pair), .bit_o(dbit)
  );

  cmi_align_ctrl #(
    .WIN_PAIRS(WIN_PAIRS), .VIOL_THR(VIOL_THR), .HOLD_PAIRS(HOLD_PAIRS)
  ) u_align (
    .clk(clk), .rst(rst), .bit_i(dbit), .slip_o(align_slip)
  );

  cmi_nibble_packer #(.NIB_W(NIB_W)) u_pack (
    .clk(clk), .rst(rst), .bit_vld(dbit.vld), .bit_dat(dbit.dat),
    .nib_o(nib_data), .nib_vld(nib_valid)
  );

  assign ser_data  = dbit.dat;
  assign ser_valid = dbit.vld;
  assign code_viol = dbit.viol;
endmodule

// File: rtl/cmi_nibble_decoder_chk.sv
module cmi_nibble_decoder_chk #(
  parameter int VIOL_THR   = 4,
  parameter int HOLD_PAIRS = 16
) (
  input logic clk,
  input logic rst,
  input logic cmi_mode,
  input logic ser_valid,
  input logic nib_valid,
  input logic code_viol,
  input logic align_slip
);
  localparam int GAP_MIN = HOLD_PAIRS + VIOL_THR;
  localparam int GW = $clog2(GAP_MIN + 1) + 1;
  localparam logic [GW-1:0] GAP_SAT = GW'(GAP_MIN);

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                          gap <= GAP_SAT;
    else if (align_slip)              gap <= '0;
    else if (ser_valid && gap != GAP_SAT) gap <= gap + 1'b1;
  end

  // R3: violations only come from pairs closed in CMI mode
  a_r3_nrz_no_viol: assert property (@(posedge clk) disable iff (rst)
    code_viol |-> $past(cmi_mode, 2));

  // R4: a violation always belongs to a decoded bit
  a_r4_viol_with_bit: assert property (@(posedge clk) disable iff (rst)
    code_viol |-> ser_valid);

  // R6: a nibble completes only on a decoded bit
  a_r6_nib_after_bit: assert property (@(posedge clk) disable iff (rst)
    nib_valid |-> $past(ser_valid));

  // R8: slips are separated by the hold window plus the threshold
  a_r8_slip_spacing: assert property (@(posedge clk) disable iff (rst)
    align_slip |-> (gap >= GAP_SAT));

  // R9: reset leaves all strobes low
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (!ser_valid && !nib_valid && !code_viol && !align_slip));
endmodule

bind cmi_nibble_decoder cmi_nibble_decoder_chk #(
  .VIOL_THR(VIOL_THR), .HOLD_PAIRS(HOLD_PAIRS)
) u_chk (
  .clk(clk), .rst(rst), .cmi_mode(cmi_mode), .ser_valid(ser_valid),
  .nib_valid(nib_valid), .code_viol(code_viol), .align_slip(align_slip)
);

// File: tb/test_cmi_nibble_decoder.sv
module test_cmi_nibble_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic line_a = 1'b0;
  logic line_b = 1'b0;
  logic src_sel = 1'b0;
  logic cmi_mode = 1'b1;
  logic ser_data, ser_valid, nib_valid, code_viol, align_slip;
  logic [3:0] nib_data;

  cmi_nibble_decoder i_cmi_nibble_decoder (
    .clk(clk), .rst(rst), .smp_en(smp_en), .line_a(line_a), .line_b(line_b),
    .src_sel(src_sel), .cmi_mode(cmi_mode), .ser_data(ser_data),
    .ser_valid(ser_valid), .nib_data(nib_data), .nib_valid(nib_valid),
    .code_viol(code_viol), .align_slip(align_slip)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int ser_n, nib_n, viol_n, slip_n;
  logic ser_q [256];
  logic [3:0] nib_q [64];
  int slip_at [8];
  logic enc_lvl;

  always @(negedge clk) begin
    if (ser_valid && ser_n < 256) begin ser_q[ser_n] = ser_data; ser_n++; end
    if (nib_valid && nib_n < 64) begin nib_q[nib_n] = nib_data; nib_n++; end
    if (code_viol) viol_n++;
    if (align_slip) begin
      if (slip_n < 8) slip_at[slip_n] = ser_n;
      slip_n++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    ser_n = 0; nib_n = 0; viol_n = 0; slip_n = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    enc_lvl = 1'b0;
    clr();
  endtask

  task automatic put(input logic b);
    @(negedge clk);
    line_a = src_sel ? ~b : b;
    line_b = src_sel ? b : ~b;
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic put_cmi(input logic b);
    if (b) begin put(enc_lvl); put(enc_lvl); enc_lvl = ~enc_lvl; end
    else begin put(1'b0); put(1'b1); end
  endtask

  task automatic flush();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(!ser_valid && !nib_valid && !code_viol && !align_slip, "R9 reset strobes",
          {ser_valid, nib_valid, code_viol, align_slip}, 0);
    do_reset();
  endtask

  task automatic t_cmi_basic();
    logic [7:0] pat = 8'b0110_1001;
    do_reset();
    for (int i = 7; i >= 0; i--) put_cmi(pat[i]);
    flush();
    check(ser_n == 8, "R2 bit count", ser_n, 8);
    for (int i = 0; i < 8; i++)
      check(ser_q[i] == pat[7-i], "R2 decoded bit", ser_q[i], pat[7-i]);
    check(nib_n == 2 && nib_q[0] == 4'h6, "R6 first nibble MSB first", nib_q[0], 6);
    check(nib_q[1] == 4'h9, "R6 second nibble", nib_q[1], 9);
    check(viol_n == 0, "R5 alternating ones clean", viol_n, 0);
  endtask

  task automatic t_latency();
    do_reset();
    put(1'b1);
    @(negedge clk);
    line_a = 1'b1; line_b = 1'b0; smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    check(ser_valid == 1'b0, "R2 no output at accept edge", ser_valid, 0);
    @(negedge clk);
    check(ser_valid && ser_data, "R2 output one cycle later", {ser_valid, ser_data}, 3);
    flush();
  endtask

  task automatic t_nrz();
    logic [7:0] pat = 8'b1101_0010;
    do_reset();
    cmi_mode = 1'b0;
    for (int i = 7; i >= 0; i--) put(pat[i]);
    flush();
    check(ser_n == 8, "R3 one bit per sample", ser_n, 8);
    check(nib_n == 2 && nib_q[0] == 4'hD, "R3 nrz nibble 0", nib_q[0], 13);
    check(nib_q[1] == 4'h2, "R3 nrz nibble 1", nib_q[1], 2);
    check(viol_n == 0, "R3 no violation in nrz", viol_n, 0);
    cmi_mode = 1'b1;
  endtask

  task automatic t_select();
    do_reset();
    src_sel = 1'b1;
    put_cmi(0); put_cmi(0); put_cmi(1); put_cmi(1);
    flush();
    check(nib_n == 1 && nib_q[0] == 4'h3, "R1 line_b selected", nib_q[0], 3);
    check(viol_n == 0, "R1 line_a ignored", viol_n, 0);
    src_sel = 1'b0;
  endtask

  task automatic t_bad_pair();
    do_reset();
    put(1'b1); put(1'b0);
    flush();
    check(viol_n == 1, "R4 pair 10 flagged", viol_n, 1);
    check(ser_n == 1 && ser_q[0] == 1'b0, "R4 pair 10 gives 0", ser_q[0], 0);
  endtask

  task automatic t_polarity();
    do_reset();
    put(1'b1); put(1'b1);
    put(1'b0); put(1'b1);
    put(1'b1); put(1'b1);
    flush();
    check(viol_n == 1, "R5 repeated level flagged once", viol_n, 1);
    check(ser_n == 3 && ser_q[0] && !ser_q[1] && ser_q[2], "R5 bits 1 0 1",
          {ser_q[0], ser_q[1], ser_q[2]}, 5);
  endtask

  task automatic t_slip();
    do_reset();
    put(1'b1);
    for (int i = 0; i < 40; i++) put_cmi(0);
    flush();
    check(slip_n == 1, "R7 one slip", slip_n, 1);
    check(viol_n == 4, "R7 four violations before slip", viol_n, 4);
    check(ser_n > 4 && ser_q[ser_n-1] == 1'b0, "R7 clean after slip", ser_q[ser_n-1], 0);
    check(nib_n > 0 && nib_q[nib_n-1] == 4'h0, "R7 last nibble zero", nib_q[nib_n-1], 0);
  endtask

  task automatic t_hold();
    do_reset();
    for (int i = 0; i < 60; i++) begin put(1'b1); put(1'b1); end
    flush();
    check(slip_n >= 2, "R8 repeated slips", slip_n, 3);
    check(slip_at[0] == 5, "R7 first slip after 5 pairs", slip_at[0], 5);
    check(slip_at[1] - slip_at[0] == 20, "R8 gap between slips", slip_at[1] - slip_at[0], 20);
  endtask

  task automatic t_reset_mid();
    do_reset();
    put_cmi(1); put_cmi(1);
    do_reset();
    put_cmi(1); put_cmi(0); put_cmi(1); put_cmi(0);
    flush();
    check(nib_n == 1 && nib_q[0] == 4'hA, "R9 nibble counter cleared", nib_q[0], 10);
    check(viol_n == 0, "R9 ones level cleared", viol_n, 0);
  endtask

  initial begin
    #4_000_000;
    tests++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clr();
    enc_lvl = 1'b0;
    t_reset();
    t_cmi_basic();
    t_latency();
    t_nrz();
    t_select();
    t_bad_pair();
    t_polarity();
    t_slip();
    t_hold();
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule